// File: doc/BRIEF.md
# Card Clock Divider and Bus Configuration

This block derives the memory-card clock from the system clock with a programmable divider, and holds the settings that describe the card bus: how many data lines are in use, whether the clock may be stalled by the data FIFO, and whether the command line drives open-drain or push-pull. The period of the card clock is the divide field plus two system clock cycles. The clock is started, stopped, re-timed and paused only at the end of a low phase, so the card never sees a shortened high or low level.

A single configuration word, written with a strobe, carries the divide request, the clock-enable bit, the bus-width code and the flow-control enable. A separate one-bit power write selects the command-line drive mode. With flow control on, a hold request from the data path (FIFO full on reads, FIFO empty on writes) parks the card clock low until the request drops. This matters most for multi-block writes.

Top module: `sdclk_gen`

## Requirements
- R1: With divide value D, the card clock repeats every N = D + 2 system cycles. Each period starts with floor(N/2) cycles high and ends with N - floor(N/2) cycles low.
- R2: The divide request is cfg_wdata[9:0]. A request above 255 is stored as 255. A request of 255 or less is stored unchanged.
- R3: The clock-enable bit is cfg_wdata[10]. Once it is set, the first high cycle follows the second rising system edge after the write edge. Once it is cleared, the period in progress completes at full length and the clock then stays low.
- R4: A new divide value is first used by the period that begins at the next card-clock rising edge. The period in progress keeps its old high and low lengths.
- R5: The bus-width code is cfg_wdata[12:11]. Code 00 gives lane_mask 0x01 (1 line), code 01 gives 0x0F (4 lines) and code 10 gives 0xFF (8 lines). Code 11 is ignored and leaves the previous width in place.
- R6: The flow-control enable is cfg_wdata[13]. While it is set and fifo_hold is high, the clock stops low at the end of a low phase. When fifo_hold falls, the next high phase is at full length and starts in the cycle after the release edge. While the enable is clear, fifo_hold has no effect.
- R7: cmd_od takes the value of pwr_od_in on the edge where pwr_wr is high. 1 means open-drain and 0 means push-pull.
- R8: After reset the block is in this state: card_clk low, clock disabled, 1-line width (lane_mask 0x01), flow control off, cmd_od 1, and clk_stb low.
- R9: clk_stb is high exactly in the first high cycle of each card-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | DIV_W+6 | Configuration word (divide request, enable, width, flow control) |
| pwr_wr | input | 1 | Power-mode write strobe |
| pwr_od_in | input | 1 | Command-line drive mode to store |
| fifo_hold | input | 1 | FIFO full/empty hold request |
| card_clk | output | 1 | Divided card clock |
| clk_stb | output | 1 | First-high-cycle strobe of card_clk |
| lane_mask | output | 8 | Active data lines |
| cmd_od | output | 1 | Command line open-drain select |

## Verification
Period lengths are measured across odd and even divisors, the smallest value and the saturation boundary. A wrong offset or a wrong split would show as high or low runs off by one cycle. Divide changes and disables are issued in the middle of a high phase: a design that applied them at once would cut that phase short. The hold request is raised both with flow control on and with it off. With it on, a wrong design might stop in a high phase or resume with a runt pulse. With it off, a wrong design might stall the clock when it should not. The reserved width code is written after an 8-line setting, which catches a decoder that falls back to another width.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  typedef enum logic [1:0] {
    BW_ONE  = 2'b00,
    BW_FOUR = 2'b01,
    BW_OCT  = 2'b10,
    BW_RSVD = 2'b11
  } bus_w_e;

  localparam int LANES = 8;

  function automatic int sdc_period(input int div);
    return div + 2;
  endfunction

  function automatic int sdc_high(input int div);
    return sdc_period(div) / 2;
  endfunction

  function automatic int sdc_low(input int div);
    return sdc_period(div) - sdc_high(div);
  endfunction

  function automatic logic [LANES-1:0] sdc_lanes(input bus_w_e w);
    case (w)
      BW_FOUR: return 8'h0F;
      BW_OCT:  return 8'hFF;
      default: return 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 254,
  localparam int REQ_W  = DIV_W + 2,
  localparam int CFG_W  = REQ_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             en_q,
  output logic             fce_q,
  output bus_w_e           width_q
);

  localparam int EN_BIT  = REQ_W;
  localparam int WID_LO  = REQ_W + 1;
  localparam int FCE_BIT = REQ_W + 3;

  logic [REQ_W-1:0] req;
  logic [DIV_W-1:0] req_sat;
  bus_w_e           wid_in;
  logic             wid_ok;

  assign req     = cfg_wdata[REQ_W-1:0];
  assign req_sat = (req > {2'b00, {DIV_W{1'b1}}}) ? {DIV_W{1'b1}} : req[DIV_W-1:0];
  assign wid_in  = bus_w_e'(cfg_wdata[WID_LO+1:WID_LO]);
  assign wid_ok  = (wid_in != BW_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(RST_DIV);
      en_q    <= 1'b0;
      fce_q   <= 1'b0;
      width_q <= BW_ONE;
    end else if (cfg_wr) begin
      div_q <= req_sat;
      en_q  <= cfg_wdata[EN_BIT];
      fce_q <= cfg_wdata[FCE_BIT];
      if (wid_ok) width_q <= wid_in;
    end
  end

endmodule

// File: rtl/sdclk_pwr_reg.sv
module sdclk_pwr_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_wr,
  input  logic pwr_od_in,
  output logic od_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      od_q <= 1'b1;
    else if (pwr_wr) od_q <= pwr_od_in;
  end

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 254,
  localparam int CW     = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             card_clk,
  output logic             clk_stb,
  output logic             parked,
  output logic [DIV_W-1:0] act_div
);

  logic [CW-1:0]    cnt, cnt_n, cnt_inc, last_idx, hi_cnt;
  logic             period_end;
  logic             parked_n, clk_n, stb_n;
  logic [DIV_W-1:0] div_n;

  assign last_idx   = CW'(sdc_period(int'(act_div)) - 1);
  assign hi_cnt     = CW'(sdc_high(int'(act_div)));
  assign cnt_inc    = cnt + 1'b1;
  assign period_end = parked || (cnt == last_idx);

  always_comb begin
    cnt_n    = cnt;
    parked_n = parked;
    clk_n    = card_clk;
    stb_n    = 1'b0;
    div_n    = act_div;
    if (period_end) begin
      if (go) begin
        cnt_n    = '0;
        parked_n = 1'b0;
        clk_n    = 1'b1;
        stb_n    = 1'b1;
        div_n    = cfg_div;
      end else begin
        parked_n = 1'b1;
        clk_n    = 1'b0;
      end
    end else begin
      cnt_n = cnt_inc;
      clk_n = (cnt_inc < hi_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      parked   <= 1'b1;
      card_clk <= 1'b0;
      clk_stb  <= 1'b0;
      act_div  <= DIV_W'(RST_DIV);
    end else begin
      cnt      <= cnt_n;
      parked   <= parked_n;
      card_clk <= clk_n;
      clk_stb  <= stb_n;
      act_div  <= div_n;
    end
  end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 254
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W+5:0] cfg_wdata,
  input  logic             pwr_wr,
  input  logic             pwr_od_in,
  input  logic             fifo_hold,
  output logic             card_clk,
  output logic             clk_stb,
  output logic [7:0]       lane_mask,
  output logic             cmd_od
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] act_div;
  logic             en_q;
  logic             fce_q;
  bus_w_e           width_q;
  logic             go;
  logic             parked;

  sdclk_cfg_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .div_q     (div_q),
    .en_q      (en_q),
    .fce_q     (fce_q),
    .width_q   (width_q)
  );

  sdclk_pwr_reg u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_wr    (pwr_wr),
    .pwr_od_in (pwr_od_in),
    .od_q      (cmd_od)
  );

  assign go = en_q && !(fce_q && fifo_hold);

  sdclk_div_core #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cfg_div  (div_q),
    .card_clk (card_clk),
    .clk_stb  (clk_stb),
    .parked   (parked),
    .act_div  (act_div)
  );

  assign lane_mask = sdc_lanes(width_q);

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int CW   = DIV_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             card_clk,
  input logic             clk_stb,
  input logic [DIV_W-1:0] act_div,
  input logic             en,
  input logic             fce,
  input logic             hold,
  input logic [7:0]       lane_mask,
  input logic             pwr_wr,
  input logic             pwr_od_in,
  input logic             cmd_od
);

  logic [CW-1:0] hcnt;
  logic [15:0]   lcnt;
  logic          seen_fall;
  logic [CW-1:0] prev_lo;
  logic [CW-1:0] exp_hi;

  assign exp_hi = CW'(sdc_high(int'(act_div)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt      <= '0;
      lcnt      <= '0;
      seen_fall <= 1'b0;
      prev_lo   <= '0;
    end else begin
      hcnt    <= card_clk ? hcnt + 1'b1 : '0;
      lcnt    <= card_clk ? '0 : ((lcnt == 16'hFFFF) ? lcnt : lcnt + 1'b1);
      prev_lo <= CW'(sdc_low(int'(act_div)));
      if (!card_clk && hcnt != '0) seen_fall <= 1'b1;
    end
  end

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> hcnt == exp_hi); // R1

  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_clk) && seen_fall) |-> lcnt >= 16'(prev_lo)); // R1

  AST_DIV_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(card_clk) |-> $stable(act_div)); // R4

  AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !card_clk) |=> !card_clk); // R3

  AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fce && hold && !card_clk) |=> !card_clk); // R6

  AST_LANE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mask == 8'h01) || (lane_mask == 8'h0F) || (lane_mask == 8'hFF)); // R5

  AST_OD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_wr |=> cmd_od == $past(pwr_od_in)); // R7

  AST_STB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stb == $rose(card_clk)); // R9

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_clk  (card_clk),
  .clk_stb   (clk_stb),
  .act_div   (act_div),
  .en        (en_q),
  .fce       (fce_q),
  .hold      (fifo_hold),
  .lane_mask (lane_mask),
  .pwr_wr    (pwr_wr),
  .pwr_od_in (pwr_od_in),
  .cmd_od    (cmd_od)
);

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 150000;
  localparam int NV      = 6;
  localparam int VREQ [NV] = '{0, 1, 6, 13, 300, 1023};
  localparam int VDIV [NV] = '{0, 1, 6, 13, 255, 255};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [13:0] cfg_wdata = '0;
  logic        pwr_wr = 1'b0;
  logic        pwr_od_in = 1'b0;
  logic        fifo_hold = 1'b0;
  logic        card_clk;
  logic        clk_stb;
  logic [7:0]  lane_mask;
  logic        cmd_od;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  sdclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pwr_wr(pwr_wr), .pwr_od_in(pwr_od_in), .fifo_hold(fifo_hold),
    .card_clk(card_clk), .clk_stb(clk_stb), .lane_mask(lane_mask), .cmd_od(cmd_od)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] word(input int req, input bit en, input int wid, input bit fce);
    return {fce, 2'(wid), en, 10'(req)};
  endfunction

  task automatic wr_cfg(input int req, input bit en, input int wid, input bit fce);
    cfg_wdata = word(req, en, wid, fce);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    int guard = 0;
    do begin
      p = card_clk;
      @(negedge clk);
      guard++;
    end while (!(card_clk && !p) && guard < 3000);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (card_clk == lvl && n < 3000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    check("R9 strobe at rise", int'(clk_stb), 1);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected 0", WD_CYC);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, n, rises;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 card_clk", int'(card_clk), 0);
    check("R8 lane_mask", int'(lane_mask), 8'h01);
    check("R8 cmd_od", int'(cmd_od), 1);
    check("R8 clk_stb", int'(clk_stb), 0);
    repeat (5) @(negedge clk);
    check("R8 stays low while disabled", int'(card_clk), 0);

    // R3 start timing
    wr_cfg(6, 1'b1, 0, 1'b0);
    check("R3 low after write edge", int'(card_clk), 0);
    @(negedge clk);
    check("R3 high after second edge", int'(card_clk), 1);

    // R1 R2 vector table
    for (int i = 0; i < NV; i++) begin
      int np;
      np = VDIV[i] + 2;
      wr_cfg(VREQ[i], 1'b1, 0, 1'b0);
      measure(hi, lo);
      measure(hi, lo);
      check($sformatf("R1 R2 high req %0d", VREQ[i]), hi, np / 2);
      check($sformatf("R1 R2 low req %0d", VREQ[i]), lo, np - np / 2);
    end

    // R4 divide change mid-high
    wr_cfg(6, 1'b1, 0, 1'b0);
    wait_rise();
    cfg_wdata = word(2, 1'b1, 0, 1'b0);
    cfg_wr = 1'b1;
    hi = 0;
    while (card_clk && hi < 3000) begin
      hi++;
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    run_len(1'b0, lo);
    check("R4 old high kept", hi, 4);
    check("R4 old low kept", lo, 4);
    measure(hi, lo);
    check("R4 new high", hi, 2);
    check("R4 new low", lo, 2);

    // R3 disable mid-high
    wr_cfg(6, 1'b1, 0, 1'b0);
    wait_rise();
    cfg_wdata = word(6, 1'b0, 0, 1'b0);
    cfg_wr = 1'b1;
    hi = 0;
    while (card_clk && hi < 3000) begin
      hi++;
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    check("R3 high completes", hi, 4);
    rises = 0;
    for (int k = 0; k < 40; k++) begin
      if (card_clk) rises++;
      @(negedge clk);
    end
    check("R3 stays low after disable", rises, 0);

    // R6 hold with flow control on
    wr_cfg(2, 1'b1, 0, 1'b1);
    wait_rise();
    fifo_hold = 1'b1;
    repeat (10) @(negedge clk);
    rises = 0;
    for (int k = 0; k < 20; k++) begin
      if (card_clk) rises++;
      @(negedge clk);
    end
    check("R6 parked low under hold", rises, 0);
    fifo_hold = 1'b0;
    @(negedge clk);
    check("R6 resumes next cycle", int'(card_clk), 1);
    run_len(1'b1, hi);
    check("R6 full high after resume", hi, 2);

    // R6 hold ignored with flow control off
    wr_cfg(2, 1'b1, 0, 1'b0);
    fifo_hold = 1'b1;
    rises = 0;
    for (int k = 0; k < 40; k++) begin
      logic p;
      p = card_clk;
      @(negedge clk);
      if (card_clk && !p) rises++;
    end
    fifo_hold = 1'b0;
    check("R6 hold ignored when off", int'(rises >= 9), 1);

    // R5 bus width codes
    wr_cfg(2, 1'b1, 1, 1'b0);
    check("R5 width 4", int'(lane_mask), 8'h0F);
    wr_cfg(2, 1'b1, 2, 1'b0);
    check("R5 width 8", int'(lane_mask), 8'hFF);
    wr_cfg(2, 1'b1, 3, 1'b0);
    check("R5 reserved ignored", int'(lane_mask), 8'hFF);
    wr_cfg(2, 1'b1, 0, 1'b0);
    check("R5 width 1", int'(lane_mask), 8'h01);

    // R7 drive mode
    pwr_od_in = 1'b0;
    pwr_wr = 1'b1;
    @(negedge clk);
    pwr_wr = 1'b0;
    check("R7 push-pull", int'(cmd_od), 0);
    pwr_od_in = 1'b1;
    @(negedge clk);
    check("R7 no write no change", int'(cmd_od), 0);
    pwr_wr = 1'b1;
    @(negedge clk);
    pwr_wr = 1'b0;
    check("R7 open-drain", int'(cmd_od), 1);

    n = checks;
    $display("CHECKS %0d ERRORS %0d", n, errors);
    $finish;
  end

endmodule